// File: doc/BRIEF.md
# Flash Sector Protection Register

This block holds the 8-bit protection setting of a program-flash array and judges every program or erase request against it. The setting names two protected windows: one at the top end of the array and one starting at a fixed low base address. Each window has its own disable bit and a 2-bit size code. An open-mode bit decides whether only those windows are locked, or the whole array is locked.

While reset is held, the register takes the configuration byte read out of flash on every clock. If that read reports a double-bit fault, the register takes a fully-locked value instead. After reset, a bus write changes the register only if no field of the write loosens the protection. A second bus address holds the violation status, which is cleared by writing 1.

A request is answered one clock after it is presented, with an allow or a deny. A deny also sets a sticky violation flag.

Top module: `flash_prot_guard`

## Requirements
- R1: While `rst` is high and `boot_dbl` is low, each clock edge loads `boot_byte` into `prot_q`. The violation flag, `resp_valid` and `resp_ok` read 0.
- R2: While `rst` is high and `boot_dbl` is high, each clock edge loads `prot_q` = 8'h7F: bit 7 (open mode) clear and bits 6:0 set.
- R3: Bit 6 of `prot_q` is reserved. A bus write never changes it.
- R4: A write to `bus_sel`=0 is applied on the next edge when it loosens no field. Fields: bit 7 open mode, bit 5 high-window disable, bits 4:3 high size code, bit 2 low-window disable, bits 1:0 low size code. Each of these counts as tightening: clearing bit 7, clearing a disable bit, or raising a size code while that window is enabled.
- R5: A write that loosens any field is ignored as a whole. Loosening means one of these: setting bit 7 from 0, setting a disable bit of an enabled window, or lowering the size code of an enabled window.
- R6: With bit 7 set and bit 5 clear, the top (UNIT << code) bytes of the array are protected. UNIT is 2 KB, so code 0 to 3 covers 2, 4, 8 or 16 KB.
- R7: With bit 7 set and bit 2 clear, the (UNIT << code) bytes starting at LOW_BASE are protected. Addresses below LOW_BASE and from the window end upward are not.
- R8: With bit 7 clear, every request is denied.
- R9: `req_kind[1]`=1 marks a whole-block erase. It is denied when any location is protected: bit 7 clear, bit 5 clear or bit 2 clear. Otherwise it is allowed. `req_kind[1]`=0 marks a program or sector erase, judged by `req_addr`.
- R10: A denied request sets `viol_flag` on the same edge that presents its response. The flag then stays set through later allowed requests.
- R11: A write to `bus_sel`=1 with bit 0 set clears `viol_flag`. Bit 0 clear has no effect. A denial on the same edge wins over the clear.
- R12: `resp_valid` pulses on the edge after `req_valid`. `resp_ok` is 1 only with `resp_valid` and an allowed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; register loads during it |
| boot_byte | input | 8 | Protection byte fetched from flash for the reset load |
| boot_dbl | input | 1 | Double-bit fault reported on that fetch |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel | input | 1 | 0 selects protection register, 1 selects status |
| bus_wdata | input | 8 | Bus write data |
| req_valid | input | 1 | Program/erase request strobe |
| req_kind | input | 2 | Request type; bit 1 set means whole-block erase |
| req_addr | input | ADDR_W | Byte address of the request |
| prot_q | output | 8 | Current protection register |
| resp_valid | output | 1 | Response strobe, one cycle after request |
| resp_ok | output | 1 | Request allowed |
| viol_flag | output | 1 | Sticky protection-violation flag |

## Verification
Every result lands exactly one edge after its cause. `prot_q` follows a reset load or an accepted write on the next edge. `resp_valid`, `resp_ok` and a newly set `viol_flag` follow a request on the next edge, and a status clear also shows on the next edge. The bench drives inputs just after a falling edge. A behavioural model advances on the rising edge from those same inputs, and every output is compared to it at the following falling edge. Each comparison therefore sees exactly one register stage of latency. The model judges requests against the register value held before any write on the same edge.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef struct packed {
    logic       open;
    logic       rsvd;
    logic       hi_off;
    logic [1:0] hi_sz;
    logic       lo_off;
    logic [1:0] lo_sz;
  } prot_t;

  localparam prot_t LOCK_ALL = prot_t'(8'h7F);

  // a window loosens when it was enabled and is now disabled or smaller
  function automatic logic window_loosens(logic off_o, logic [1:0] sz_o,
                                          logic off_n, logic [1:0] sz_n);
    return !off_o && (off_n || (sz_n < sz_o));
  endfunction

  function automatic logic loosens(prot_t cur, prot_t nxt);
    return (!cur.open && nxt.open)
        || window_loosens(cur.hi_off, cur.hi_sz, nxt.hi_off, nxt.hi_sz)
        || window_loosens(cur.lo_off, cur.lo_sz, nxt.lo_off, nxt.lo_sz);
  endfunction

endpackage

// File: rtl/guard_region.sv
module guard_region #(
  parameter int ADDR_W = 17,
  parameter int UNIT   = 2048,
  parameter int BASE   = 32768,
  parameter bit AT_TOP = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              off,
  input  logic [1:0]        sz,
  output logic              hit
);
  localparam int AW1 = ADDR_W + 1;

  logic [AW1-1:0] span;
  logic [AW1-1:0] start;
  logic [AW1-1:0] a_ext;

  always_comb begin
    span  = AW1'(UNIT) << sz;
    a_ext = {1'b0, addr};
    if (AT_TOP) start = (AW1'(1) << ADDR_W) - span;
    else        start = AW1'(BASE);
    hit = !off && (a_ext >= start) && (a_ext < start + span);
  end
endmodule

// File: rtl/guard_reg.sv
module guard_reg
  import guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] boot_byte,
  input  logic       boot_dbl,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output prot_t      q
);
  prot_t req_n;
  logic  accept;
  logic  unused_rsvd;

  assign unused_rsvd = wdata[6];

  always_comb begin
    req_n      = prot_t'(wdata);
    req_n.rsvd = q.rsvd;
    accept     = !loosens(q, req_n);
  end

  always_ff @(posedge clk) begin
    if (rst)                 q <= boot_dbl ? LOCK_ALL : prot_t'(boot_byte);
    else if (wr_en && accept) q <= req_n;
  end
endmodule

// File: rtl/guard_check.sv
module guard_check (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic blk_erase,
  input  logic addr_prot,
  input  logic any_prot,
  input  logic clr_flag,
  output logic resp_valid,
  output logic resp_ok,
  output logic viol
);
  logic deny;

  assign deny = blk_erase ? any_prot : addr_prot;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      viol       <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_ok    <= req_valid && !deny;
      if (req_valid && deny) viol <= 1'b1;
      else if (clr_flag)     viol <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_prot_guard.sv
module flash_prot_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int UNIT     = 2048,
  parameter int LOW_BASE = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        boot_byte,
  input  logic              boot_dbl,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [7:0]        bus_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        prot_q,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic              viol_flag
);
  prot_t      cur;
  logic [1:0] hit;
  logic       addr_prot;
  logic       any_prot;

  guard_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .boot_byte (boot_byte),
    .boot_dbl  (boot_dbl),
    .wr_en     (bus_wr && !bus_sel),
    .wdata     (bus_wdata),
    .q         (cur)
  );

  for (genvar g = 0; g < 2; g++) begin : g_win
    guard_region #(
      .ADDR_W (ADDR_W),
      .UNIT   (UNIT),
      .BASE   (LOW_BASE),
      .AT_TOP (g == 0)
    ) u_win (
      .addr (req_addr),
      .off  ((g == 0) ? cur.hi_off : cur.lo_off),
      .sz   ((g == 0) ? cur.hi_sz  : cur.lo_sz),
      .hit  (hit[g])
    );
  end

  assign addr_prot = !cur.open || (|hit);
  assign any_prot  = !cur.open || !cur.hi_off || !cur.lo_off;

  guard_check u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .blk_erase  (req_kind[1]),
    .addr_prot  (addr_prot),
    .any_prot   (any_prot),
    .clr_flag   (bus_wr && bus_sel && bus_wdata[0]),
    .resp_valid (resp_valid),
    .resp_ok    (resp_ok),
    .viol       (viol_flag)
  );

  assign prot_q = cur;
endmodule

// File: rtl/flash_prot_guard_chk.sv
module flash_prot_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_sel,
  input logic [7:0] bus_wdata,
  input logic       req_valid,
  input logic [7:0] prot_q,
  input logic       resp_valid,
  input logic       resp_ok,
  input logic       viol_flag
);
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid); // R12
  AST_OK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    resp_ok |-> resp_valid); // R12
  AST_LOCKED_DENY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prot_q[7]) |=> !resp_ok); // R8
  AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ok) |-> viol_flag); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && !(bus_wr && bus_sel && bus_wdata[0])) |=> viol_flag); // R11
  AST_RSVD_FIXED: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(prot_q[6])); // R3
  AST_NO_REOPEN: assert property (@(posedge clk) disable iff (rst)
    !prot_q[7] |=> !prot_q[7]); // R5
endmodule

bind flash_prot_guard flash_prot_guard_chk u_guard_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_sel    (bus_sel),
  .bus_wdata  (bus_wdata),
  .req_valid  (req_valid),
  .prot_q     (prot_q),
  .resp_valid (resp_valid),
  .resp_ok    (resp_ok),
  .viol_flag  (viol_flag)
);

// File: tb/sim_flash_prot_guard.sv
`timescale 1ns/1ps
module sim_flash_prot_guard;
  localparam int AW   = 17;
  localparam int SIZE = 1 << AW;
  localparam int LOWB = 32768;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    boot_byte = 8'hFF;
  logic          boot_dbl = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_sel = 1'b0;
  logic [7:0]    bus_wdata = 8'h00;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    prot_q;
  logic          resp_valid, resp_ok, viol_flag;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  logic [7:0] m_prot = 8'h00;
  logic       m_rv = 1'b0, m_ok = 1'b0, m_flag = 1'b0;

  always #2.5 clk = ~clk;

  flash_prot_guard u0 (
    .clk(clk), .rst(rst), .boot_byte(boot_byte), .boot_dbl(boot_dbl),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .prot_q(prot_q), .resp_valid(resp_valid), .resp_ok(resp_ok),
    .viol_flag(viol_flag)
  );

  function automatic bit prot_at(int a, logic [7:0] p);
    int hs, ls;
    if (!p[7]) return 1'b1;
    hs = 2048 << p[4:3];
    ls = 2048 << p[1:0];
    if (!p[5] && a >= SIZE - hs) return 1'b1;
    if (!p[2] && a >= LOWB && a < LOWB + ls) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit reduces(logic [7:0] o, logic [7:0] n);
    bit r;
    r = (!o[7] && n[7]);
    if (!o[5] && (n[5] || n[4:3] < o[4:3])) r = 1'b1;
    if (!o[2] && (n[2] || n[1:0] < o[1:0])) r = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    bit dn;
    if (rst) begin
      m_prot = boot_dbl ? 8'h7F : boot_byte;
      m_rv = 1'b0; m_ok = 1'b0; m_flag = 1'b0;
    end else begin
      if (req_kind[1]) dn = !m_prot[7] || !m_prot[5] || !m_prot[2];
      else             dn = prot_at(int'(req_addr), m_prot);
      m_rv = req_valid;
      m_ok = req_valid && !dn;
      if (req_valid && dn) m_flag = 1'b1;
      else if (bus_wr && bus_sel && bus_wdata[0]) m_flag = 1'b0;
      if (bus_wr && !bus_sel && !reduces(m_prot, bus_wdata))
        m_prot = {bus_wdata[7], m_prot[6], bus_wdata[5:0]};
    end
  end

  always @(negedge clk) begin
    checks += 3;
    if (prot_q !== m_prot) begin
      errors++;
      $display("FAIL %s prot_q act=%h exp=%h", tag, prot_q, m_prot);
    end
    if ({resp_valid, resp_ok} !== {m_rv, m_ok}) begin
      errors++;
      $display("FAIL %s resp act=%b%b exp=%b%b", tag, resp_valid, resp_ok, m_rv, m_ok);
    end
    if (viol_flag !== m_flag) begin
      errors++;
      $display("FAIL %s viol_flag act=%b exp=%b", tag, viol_flag, m_flag);
    end
  end

  task automatic boot(input logic [7:0] b, input logic d);
    rst = 1'b1; boot_byte = b; boot_dbl = d;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic req(input logic [1:0] k, input int a);
    req_valid = 1'b1; req_kind = k; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    tag = "R1";  boot(8'hFF, 1'b0);
    boot(8'hB6, 1'b0);
    tag = "R2";  boot(8'hA5, 1'b1);
    tag = "R8";  req(2'b00, 0); req(2'b01, SIZE - 1);
    tag = "R1";  boot(8'hFF, 1'b0);
    tag = "R3";  wr(1'b0, 8'hBF);
    tag = "R4";  wr(1'b0, 8'h84); wr(1'b0, 8'h9C);
    tag = "R6";  req(2'b00, SIZE - 1); req(2'b01, 'h1C000); req(2'b00, 'h1BFFF);
    tag = "R10"; req(2'b00, 0); req(2'b00, 'h100);
    tag = "R11"; wr(1'b1, 8'hFE); wr(1'b1, 8'h01);
    req(2'b00, SIZE - 2);
    bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'h01;
    req_valid = 1'b1; req_kind = 2'b00; req_addr = AW'(SIZE - 3);
    @(negedge clk);
    bus_wr = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    wr(1'b1, 8'h01);
    tag = "R5";  wr(1'b0, 8'h94); wr(1'b0, 8'hBC); wr(1'b0, 8'h88);
    tag = "R7";  wr(1'b0, 8'h99);
    req(2'b00, LOWB); req(2'b01, LOWB + 'hFFF); req(2'b00, LOWB + 'h1000);
    req(2'b00, LOWB - 1);
    tag = "R9";  req(2'b10, 0);
    boot(8'hFF, 1'b0);
    req(2'b11, 0); req(2'b00, 'h4000);
    tag = "R8";  wr(1'b0, 8'h7F); req(2'b00, 'h4000);
    tag = "R5";  wr(1'b0, 8'hFF);
    tag = "R12"; req(2'b00, 'h2000); req(2'b10, 0);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule